// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block carries 32-bit words from a producer clocked by `wr_clk` to a consumer clocked by `rd_clk`. The two clocks may be unrelated or may be the same net. Words are stored in a 512-entry array. Each side has its own select and enable inputs. A word moves only on a rising edge of that side's clock, and only while the side's select is low and its enable is high.

The producer sees `in_ready`, and the consumer sees `out_ready`. The read side works in fall-through mode. The oldest word is fetched from the array into an output register before anyone asks for it. When `out_ready` is high, `rd_data` already holds that word, and a read accepts it. The read port would drive a shared bus. Its drive enable comes out as `rd_oe` and is not modelled as a tri-state buffer.

Each pointer crosses to the other clock domain as a Gray code through a chain of flops. A single active-low reset clears both sides at once. Each domain releases that reset in step with its own clock.

Top module: `xfifo_fwft`

## Requirements
- R1: A word is written only on a `wr_clk` rising edge with `wr_sel_n` low and `wr_en` high. A word is read only on a `rd_clk` rising edge with `rd_sel_n` low and `rd_en` high. Any other input combination moves no data.
- R2: `rd_oe` is high exactly while `rd_sel_n` is low. Whenever `rd_sel_n` is high, the data outputs count as undriven.
- R3: While `in_ready` is low, the FIFO is full and no write reaches the array. Start from empty, keep reads idle and write continuously: exactly DEPTH+1 words are accepted (DEPTH in the array plus one in the output register), and then `in_ready` stays low.
- R4: `in_ready` is low while `rst_n` is low. After `rst_n` rises, it goes high on the second `wr_clk` rising edge.
- R5: `out_ready` is low after reset. With the default two synchronizer stages, it rises on the third `rd_clk` rising edge after the edge that writes a word into an empty FIFO. While `out_ready` is low, reads are blocked.
- R6: While `out_ready` is high, `rd_data` holds the oldest unread word, and it does not change until that word is read. Words leave in the order they were accepted.
- R7: A write attempted while `in_ready` is low is ignored, and so is a read attempted while `out_ready` is low. No word is lost, duplicated or added.
- R8: Driving `rst_n` low drops `in_ready` and `out_ready` at once, without waiting for a clock edge, and discards all stored words.
- R9: Take a full FIFO and read once, so that a word moves from the array into the output register. `in_ready` rises again on the second `wr_clk` rising edge after that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_sel_n | input | 1 | Write-side select, active low |
| wr_en | input | 1 | Write-side enable, active high |
| wr_data | input | DATA_W | Word to store |
| in_ready | output | 1 | High when a write will be accepted |
| rd_sel_n | input | 1 | Read-side select, active low |
| rd_en | input | 1 | Read-side enable, active high |
| rd_data | output | DATA_W | Output register holding the oldest word |
| rd_oe | output | 1 | Drive enable for the read data bus |
| out_ready | output | 1 | High when `rd_data` is valid and a read will be accepted |

## Verification
Two functions can fall on the same edge. A read can empty the output register on the edge where a fresh word is fetched from the array to refill it. The write that fills the last free slot can arrive on the edge where the read side frees one. The bench provokes both by holding both clocks on one net and asserting write and read together for long stretches, at fill levels near empty and near full. It judges each edge against a behavioural queue model. That model delays the two occupancy counts by the synchronizer depth, and on every cycle it predicts `in_ready`, `out_ready`, `rd_oe` and `rd_data`.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

   // Smallest legal synchronizer chain and array size.
   localparam int unsigned XF_MIN_SYNC  = 2;
   localparam int unsigned XF_MIN_DEPTH = 4;

   // True when n is a non-zero power of two.
   function automatic bit xf_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/xfifo_sync.sv
// Multi-flop synchronizer with asynchronous clear. Used both for Gray
// pointers and (with d tied high) as a reset-release synchronizer.
module xfifo_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int unsigned CHAIN_W = STAGES * WIDTH;

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[CHAIN_W-WIDTH-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/xfifo_wr_ctl.sv
// Write-side pointer, full detection and input-ready flag.
module xfifo_wr_ctl #(
   parameter int unsigned AW = 9
) (
   input  logic          clk,
   input  logic          lrst_n,
   input  logic          sel_n,
   input  logic          en,
   input  logic [AW:0]   rgray_s,
   output logic [AW:0]   wgray,
   output logic [AW-1:0] waddr,
   output logic          fire,
   output logic          in_ready
);
   localparam int unsigned   PW   = AW + 1;
   localparam logic [PW-1:0] SPAN = PW'(1) << AW;

   logic [PW-1:0] wbin;
   logic [PW-1:0] wbin_nx;
   logic [PW-1:0] rbin_s;
   logic          full;

   // Full: the two top Gray bits differ and the rest match.
   assign full     = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
   assign in_ready = lrst_n & ~full;
   assign fire     = ~sel_n & en & in_ready;
   assign wbin_nx  = wbin + PW'(fire);
   assign waddr    = wbin[AW-1:0];

   always_ff @(posedge clk or negedge lrst_n) begin
      if (!lrst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   // Binary view of the synchronized read pointer.
   for (genvar i = 0; i < PW; i++) begin : g_g2b
      assign rbin_s[i] = ^rgray_s[AW:i];
   end

   // R3: the writer never runs more than a full array ahead of the reader.
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!lrst_n)
      (wbin - rbin_s) <= SPAN)
      else $error("write pointer ran past the array span");

   // R3: the crossing pointer moves by at most one bit per edge.
   assert_gray_step_R3: assert property (@(posedge clk) disable iff (!lrst_n)
      $countones(wgray ^ $past(wgray)) <= 1)
      else $error("write Gray pointer changed by more than one bit");
endmodule

// File: rtl/xfifo_rd_ctl.sv
// Read-side pointer, empty detection and first-word-fall-through register.
module xfifo_rd_ctl #(
   parameter int unsigned AW = 9,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          lrst_n,
   input  logic          sel_n,
   input  logic          en,
   input  logic [AW:0]   wgray_s,
   input  logic [DW-1:0] mem_q,
   output logic [AW:0]   rgray,
   output logic [AW-1:0] raddr,
   output logic [DW-1:0] rd_data,
   output logic          out_ready
);
   localparam int unsigned   PW   = AW + 1;
   localparam logic [PW-1:0] SPAN = PW'(1) << AW;

   logic [PW-1:0] rbin;
   logic [PW-1:0] rbin_nx;
   logic [PW-1:0] wbin_s;
   logic          empty;
   logic          rfire;
   logic          load;

   assign empty   = (rgray == wgray_s);
   assign rfire   = ~sel_n & en & out_ready;
   // Refill the output register when it is vacant or being consumed.
   assign load    = (~out_ready | rfire) & ~empty;
   assign rbin_nx = rbin + PW'(load);
   assign raddr   = rbin[AW-1:0];

   always_ff @(posedge clk or negedge lrst_n) begin
      if (!lrst_n) begin
         rbin      <= '0;
         rgray     <= '0;
         rd_data   <= '0;
         out_ready <= 1'b0;
      end else begin
         rbin  <= rbin_nx;
         rgray <= rbin_nx ^ (rbin_nx >> 1);
         if (load) begin
            rd_data   <= mem_q;
            out_ready <= 1'b1;
         end else if (rfire) begin
            out_ready <= 1'b0;
         end
      end
   end

   for (genvar i = 0; i < PW; i++) begin : g_g2b
      assign wbin_s[i] = ^wgray_s[AW:i];
   end

   // R5: the fetch pointer never passes the synchronized write pointer.
   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!lrst_n)
      (wbin_s - rbin) <= SPAN)
      else $error("read pointer passed the write pointer");

   // R5: the crossing pointer moves by at most one bit per edge.
   assert_gray_step_R5: assert property (@(posedge clk) disable iff (!lrst_n)
      $countones(rgray ^ $past(rgray)) <= 1)
      else $error("read Gray pointer changed by more than one bit");

   // R6: a presented word stays put until it is consumed.
   assert_hold_word_R6: assert property (@(posedge clk) disable iff (!lrst_n)
      (out_ready && !rfire) |=> (out_ready && $stable(rd_data)))
      else $error("output word changed before being read");

   // R7: consuming the last word with nothing behind it drops output-ready.
   assert_drain_R7: assert property (@(posedge clk) disable iff (!lrst_n)
      (rfire && empty) |=> !out_ready)
      else $error("output-ready stayed high after the last word left");
endmodule

// File: rtl/xfifo_fwft.sv
module xfifo_fwft #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned DEPTH       = 512,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_sel_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              in_ready,
   input  logic              rd_sel_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe,
   output logic              out_ready
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned PW = AW + 1;

   // Elaboration-time parameter checks.
   if (!xfifo_pkg::xf_pow2(DEPTH) || (DEPTH < xfifo_pkg::XF_MIN_DEPTH)) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least four");
   end
   if (SYNC_STAGES < xfifo_pkg::XF_MIN_SYNC) begin : g_bad_sync
      $error("SYNC_STAGES must be at least two");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least one");
   end

   logic              wr_lrst_n;
   logic              rd_lrst_n;
   logic [PW-1:0]     wgray;
   logic [PW-1:0]     rgray;
   logic [PW-1:0]     wgray_s;
   logic [PW-1:0]     rgray_s;
   logic [AW-1:0]     waddr;
   logic [AW-1:0]     raddr;
   logic              wr_fire;
   logic [DATA_W-1:0] mem_q;
   logic [DATA_W-1:0] mem [DEPTH];

   // Reset release, one synchronizer per domain.
   xfifo_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_wr_rst (
      .clk(wr_clk), .arst_n(rst_n), .d(1'b1), .q(wr_lrst_n));
   xfifo_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rd_rst (
      .clk(rd_clk), .arst_n(rst_n), .d(1'b1), .q(rd_lrst_n));

   // Gray pointer crossings.
   xfifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .arst_n(rd_lrst_n), .d(wgray), .q(wgray_s));
   xfifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .arst_n(wr_lrst_n), .d(rgray), .q(rgray_s));

   xfifo_wr_ctl #(.AW(AW)) u_wr (
      .clk      (wr_clk),
      .lrst_n   (wr_lrst_n),
      .sel_n    (wr_sel_n),
      .en       (wr_en),
      .rgray_s  (rgray_s),
      .wgray    (wgray),
      .waddr    (waddr),
      .fire     (wr_fire),
      .in_ready (in_ready)
   );

   always_ff @(posedge wr_clk) begin
      if (wr_fire) mem[waddr] <= wr_data;
   end
   assign mem_q = mem[raddr];

   xfifo_rd_ctl #(.AW(AW), .DW(DATA_W)) u_rd (
      .clk       (rd_clk),
      .lrst_n    (rd_lrst_n),
      .sel_n     (rd_sel_n),
      .en        (rd_en),
      .wgray_s   (wgray_s),
      .mem_q     (mem_q),
      .rgray     (rgray),
      .raddr     (raddr),
      .rd_data   (rd_data),
      .out_ready (out_ready)
   );

   assign rd_oe = ~rd_sel_n;
endmodule

// File: tb/xfifo_fwft_tb_top.sv
module xfifo_fwft_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW         = 32;
   localparam int DEPTH      = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_sel_n, wr_en, rd_sel_n, rd_en;
   logic [DW-1:0] wr_data;
   logic          in_ready, out_ready, rd_oe;
   logic [DW-1:0] rd_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   xfifo_fwft #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
      .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
      .wr_sel_n(wr_sel_n), .wr_en(wr_en), .wr_data(wr_data), .in_ready(in_ready),
      .rd_sel_n(rd_sel_n), .rd_en(rd_en), .rd_data(rd_data), .rd_oe(rd_oe),
      .out_ready(out_ready)
   );

   int checks = 0;
   int errors = 0;

   // Behavioural reference: a queue plus occupancy counts seen through a
   // two-edge delay on each side.
   logic [DW-1:0] mq[$];
   logic [DW-1:0] m_dout;
   bit            m_or, m_rst;
   int            live_cnt, wc, fc, wc_s1, wc_s2, fc_s1, fc_s2;

   bit            o_ir, o_or;
   logic [DW-1:0] o_data;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   function automatic bit exp_ir();
      return !m_rst && (live_cnt >= 2) && ((wc - fc_s2) != DEPTH);
   endfunction

   task automatic model_reset();
      mq.delete();
      m_dout = '0; m_or = 1'b0; m_rst = 1'b1; live_cnt = 0;
      wc = 0; fc = 0; wc_s1 = 0; wc_s2 = 0; fc_s1 = 0; fc_s2 = 0;
   endtask

   task automatic model_step(input bit wsn, input bit wen, input logic [DW-1:0] wd,
                             input bit rsn, input bit ren);
      bit live, wf, rf, empty;
      int wc_pre, fc_pre;
      if (m_rst) return;
      live   = (live_cnt >= 2);
      wf     = !wsn && wen && exp_ir();
      rf     = !rsn && ren && m_or;
      empty  = (fc == wc_s2);
      wc_pre = wc;
      fc_pre = fc;
      if (live) begin
         if ((!m_or || rf) && !empty) begin
            m_dout = mq.pop_front();
            fc++;
            m_or = 1'b1;
         end else if (rf) begin
            m_or = 1'b0;
         end
         wc_s2 = wc_s1; wc_s1 = wc_pre;
         fc_s2 = fc_s1; fc_s1 = fc_pre;
         if (wf) begin
            mq.push_back(wd);
            wc++;
         end
      end
      if (live_cnt < 2) live_cnt++;
   endtask

   task automatic compare();
      check(in_ready === exp_ir(), "R3/R4", "in_ready", DW'(in_ready), DW'(exp_ir()));
      check(out_ready === m_or, "R5", "out_ready", DW'(out_ready), DW'(m_or));
      check(rd_oe === ~rd_sel_n, "R2", "rd_oe", DW'(rd_oe), DW'(~rd_sel_n));
      if (m_or) check(rd_data === m_dout, "R6/R7/R1", "rd_data", rd_data, m_dout);
   endtask

   task automatic cycle(input bit wsn, input bit wen, input logic [DW-1:0] wd,
                        input bit rsn, input bit ren);
      @(negedge clk);
      compare();
      o_ir = in_ready; o_or = out_ready; o_data = rd_data;
      wr_sel_n = wsn; wr_en = wen; wr_data = wd; rd_sel_n = rsn; rd_en = ren;
      model_step(wsn, wen, wd, rsn, ren);
   endtask

   task automatic idle();
      cycle(1'b1, 1'b0, '0, 1'b1, 1'b0);
   endtask

   task automatic release_reset();
      @(negedge clk);
      rst_n = 1'b1;
      m_rst = 1'b0;
      live_cnt = 0;
      model_step(1'b1, 1'b0, '0, 1'b1, 1'b0);
   endtask

   task automatic async_reset();
      @(negedge clk);
      #2 rst_n = 1'b0;
      #1;
      check(in_ready === 1'b0, "R8", "in_ready after async reset", DW'(in_ready), 0);
      check(out_ready === 1'b0, "R8", "out_ready after async reset", DW'(out_ready), 0);
      model_reset();
      for (int i = 0; i < 3; i++) idle();
      release_reset();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int            k, acc, idx;
      logic [DW-1:0] nxt;
      rst_n = 1'b0;
      wr_sel_n = 1'b1; wr_en = 1'b0; wr_data = '0; rd_sel_n = 1'b1; rd_en = 1'b0;
      model_reset();
      for (int i = 0; i < 4; i++) idle();
      check(in_ready === 1'b0, "R4", "in_ready in reset", DW'(in_ready), 0);
      check(out_ready === 1'b0, "R5", "out_ready in reset", DW'(out_ready), 0);

      // R4: in_ready rises on the second edge after release.
      release_reset();
      k = 0;
      do begin idle(); k++; end while (!o_ir && k < 10);
      check(k == 2, "R4", "edges to in_ready", DW'(k), 2);

      // R5: third edge after a write into an empty FIFO.
      cycle(1'b0, 1'b1, 32'h1111_0001, 1'b1, 1'b0);
      k = 0;
      do begin idle(); k++; end while (!o_or && k < 10);
      check(k - 1 == 3, "R5", "edges to out_ready", DW'(k - 1), 3);
      check(o_data === 32'h1111_0001, "R6", "first word", o_data, 32'h1111_0001);
      cycle(1'b1, 1'b0, '0, 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) idle();

      // R1: select or enable inactive moves nothing.
      for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 32'hBAD0_0000 + i, 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 32'hBAD1_0000 + i, 1'b1, 1'b0);
      for (int i = 0; i < 5; i++) idle();
      check(o_or == 1'b0, "R1", "no word after blocked writes", DW'(o_or), 0);
      cycle(1'b0, 1'b1, 32'h2222_0002, 1'b1, 1'b0);
      for (int i = 0; i < 5; i++) idle();
      for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, '0, 1'b1, 1'b1);
      for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, '0, 1'b0, 1'b0);
      idle();
      check(o_or == 1'b1, "R1", "word kept after blocked reads", DW'(o_or), 1);
      check(o_data === 32'h2222_0002, "R1", "word value kept", o_data, 32'h2222_0002);
      cycle(1'b1, 1'b0, '0, 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) idle();

      // R3/R7: fill with reads idle, keep pushing while full.
      acc = 0;
      nxt = 32'hA000_0000;
      for (int i = 0; i < 40; i++) begin
         cycle(1'b0, 1'b1, nxt, 1'b1, 1'b0);
         if (o_ir) begin acc++; nxt++; end
      end
      check(acc == DEPTH + 1, "R3", "words accepted when full", DW'(acc), DW'(DEPTH + 1));
      idle();
      check(o_ir == 1'b0, "R3", "in_ready low when full", DW'(o_ir), 0);

      // R9: one read frees a slot; in_ready back two edges later.
      cycle(1'b1, 1'b0, '0, 1'b0, 1'b1);
      check(o_data === 32'hA000_0000, "R6", "oldest word first", o_data, 32'hA000_0000);
      k = 0;
      do begin idle(); k++; end while (!o_ir && k < 10);
      check(k - 1 == 2, "R9", "edges to in_ready after read", DW'(k - 1), 2);

      // R6/R7: drain and confirm order and count.
      idx = 1;
      for (int i = 0; i < 40; i++) begin
         cycle(1'b1, 1'b0, '0, 1'b0, 1'b1);
         if (o_or) begin
            check(o_data === 32'hA000_0000 + idx, "R6", "drain order", o_data, 32'hA000_0000 + idx);
            idx++;
         end
      end
      check(idx == DEPTH + 1, "R7", "no extra words from ignored writes", DW'(idx), DW'(DEPTH + 1));

      // Concurrent traffic: writes and reads on the same edges.
      for (int i = 0; i < 2000; i++)
         cycle(($urandom % 5) == 0, ($urandom % 6) != 0, $urandom,
               ($urandom % 4) == 0, ($urandom % 3) != 0);
      for (int i = 0; i < 2000; i++)
         cycle(($urandom % 4) == 0, ($urandom % 3) != 0, $urandom,
               ($urandom % 6) == 0, ($urandom % 5) != 0);

      // R8: asynchronous reset discards contents.
      for (int i = 0; i < 30; i++) idle();
      for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, 32'hC000_0000 + i, 1'b1, 1'b0);
      for (int i = 0; i < 6; i++) idle();
      check(o_or == 1'b1, "R8", "data present before reset", DW'(o_or), 1);
      async_reset();
      for (int i = 0; i < 10; i++) idle();
      check(o_or == 1'b0, "R8", "contents discarded", DW'(o_or), 0);
      cycle(1'b0, 1'b1, 32'hD000_0001, 1'b1, 1'b0);
      for (int i = 0; i < 5; i++) idle();
      check(o_data === 32'hD000_0001, "R6", "word after reset", o_data, 32'hD000_0001);
      cycle(1'b1, 1'b0, '0, 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) idle();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule